// File: doc/BRIEF.md
# Multithreaded Retirement and Recovery Controller

This block decides, every cycle and for each hardware thread on its own, what happens at the head of that thread's reorder buffer. An entry may retire, the head may stall, or the head may raise a trap. The buffer storage, the store buffer and the trap handler sit outside the block. They are seen only through status and handshake signals: a small window of head-entry flags and sequence numbers, a stores-awaiting-writeback flag, an occupancy count and a squash-finished flag.

Each thread has a two-bit commit state. Up to `CW` entries per thread retire in a cycle, strictly in order, and retirement halts at the first entry that cannot go. A fault becomes a trap only once the faulting entry is the first in its cycle and the store buffer is drained. The trap squashes the whole thread after a programmable delay. Squash requests from a thread-context source or from the execute stage redirect the buffer. New entries from rename are admitted only while the thread is neither recovering nor waiting on a trap. Free-entry and empty notices go back upstream. An empty notice is held back while stores are still pending or a store retires in the same cycle.

Top module: `commit_ctrl`

## Requirements
- R1: After reset every thread is in the Idle state (code 0; Running is 1, ROB-squashing is 2, trap-pending is 3) and all pulse outputs are low. An Idle thread moves to Running in the cycle after its `thr_active` bit is high.
- R2: A Running thread retires, in order, the leading run of head entries that are valid, executed and fault-free, up to `CW` per cycle. Head kind codes are: 0 plain, 1 store, 2 load, 3 serializing. The run stops at the first invalid entry, the first unexecuted entry, or the first faulting entry.
- R3: A faulting executed entry raises `trap_take` only if it is the first entry considered in that cycle and `st_wb_pending` is low. In any other case the thread just stalls at that entry.
- R4: After a trap the thread is in trap-pending. With latency setting L, a squash-all pulse (`sq_valid` and `sq_all`) appears max(L,1) cycles after the trap cycle. Its sequence number is the head entry's number minus one, or 0 if the head is invalid. The thread then enters ROB-squashing.
- R5: A thread in ROB-squashing retires nothing. It returns to Running in the cycle after `rob_sq_done` is seen with no new squash.
- R6: An unexecuted serializing entry (kind 3) whose committable bit is set, that is first in its cycle and sees no pending stores, pulses `ns_valid` with its sequence number and `ns_uncached` low. Otherwise, and always when its committable bit is clear, it stalls with no pulse.
- R7: An unexecuted load (kind 2) follows the R6 rule but pulses `ns_uncached` high together with `ns_valid`.
- R8: A thread-context squash in Running or ROB-squashing squashes the whole thread, using the R4 sequence rule. It is ignored in trap-pending. When it coincides with an execute squash, it wins.
- R9: An execute squash is accepted in Running or ROB-squashing, never in trap-pending. It reports `ex_sq_seq` minus `ex_sq_incl` with `sq_all` low. No entry retires in a cycle with an accepted squash.
- R10: `ins_accept` is high exactly when `ren_valid` is high, `ren_squashed` is low and the thread is Idle or Running.
- R11: Two cycles after any cycle in which a thread inserts, retires or squashes, `free_upd` pulses with `free_cnt` equal to `DEPTH` minus the `rob_occ` seen in the intermediate cycle.
- R12: `empty_upd` pulses only after an entry-count change has been seen with zero occupancy. It pulses in the cycle after one in which occupancy is zero, `st_wb_pending` is low and no store retired. Until then the pending check is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | NT | Per-thread enable that starts an Idle thread |
| trap_latency | input | LAT_W | Cycles from trap to squash-all (0 acts as 1) |
| st_wb_pending | input | 1 | Stores still await writeback |
| head_valid | input | NT×CW | Head window entry holds an instruction |
| head_exec | input | NT×CW | Head window entry has executed |
| head_fault | input | NT×CW | Head window entry carries a fault |
| head_commitable | input | NT×CW | Entry not yet sent back for serialized execution |
| head_kind | input | NT×CW×2 | Entry kind code (R2) |
| head_seq | input | NT×CW×SEQ_W | Entry sequence number |
| rob_occ | input | NT×CNT_W | Occupancy of each thread's buffer |
| rob_sq_done | input | NT | Buffer has finished squashing the thread |
| ex_sq_req | input | NT | Execute stage requests a squash |
| ex_sq_seq | input | NT×SEQ_W | Sequence number of the squashing instruction |
| ex_sq_incl | input | NT | Squash includes the squashing instruction |
| ctx_sq_req | input | NT | Thread-context squash request |
| ren_valid | input | NT | Rename offers an entry |
| ren_squashed | input | NT | Offered entry is already squashed |
| thr_state | output | NT×2 | Per-thread commit state code |
| retire_cnt | output | NT×RC_W | Entries retired from the head this cycle |
| trap_take | output | NT | Trap raised this cycle |
| ns_valid | output | NT | Serialized or uncached entry sent back to issue |
| ns_seq | output | NT×SEQ_W | Its sequence number |
| ns_uncached | output | NT | It is an uncached load to replay |
| sq_valid | output | NT | Squash issued to the buffer this cycle |
| sq_all | output | NT | The squash covers the whole thread |
| sq_seq | output | NT×SEQ_W | Youngest sequence number kept |
| ins_accept | output | NT | Offered rename entry is inserted |
| free_upd | output | NT | Free-entry notice valid |
| free_cnt | output | NT×CNT_W | Free entries of the thread |
| empty_upd | output | NT | Thread buffer is reported empty |

## Verification
The retirement decision for one thread is swept over every combination of two head entries. Each entry varies in valid, executed, fault, committable and kind, and each combination is tried with and without pending stores. This separates the in-order stop points, the first-in-cycle trap rule and the serialized and uncached send-back from one another. The trap delay is tried across several latency settings, including zero, with the head both valid and invalid. Squash requests are injected during the trap wait to show they are dropped. Execute and context squashes are applied alone and together to show their priority and sequence adjustment. Reporting is driven with nonzero and zero occupancy, with stores pending, and with a store retiring in the check cycle, to show when the empty notice is held back.

// File: rtl/commit_pkg.sv
package commit_pkg;

    typedef enum logic [1:0] {
        TS_IDLE   = 2'd0,
        TS_RUN    = 2'd1,
        TS_SQUASH = 2'd2,
        TS_TRAP   = 2'd3
    } thr_state_e;

    typedef enum logic [1:0] {
        EK_PLAIN  = 2'd0,
        EK_STORE  = 2'd1,
        EK_LOAD   = 2'd2,
        EK_SERIAL = 2'd3
    } entry_kind_e;

endpackage

// File: rtl/commit_head_scan.sv
module commit_head_scan
    import commit_pkg::*;
#(
    parameter int CW    = 2,
    parameter int SEQ_W = 8,
    parameter int RC_W  = 2
) (
    input  logic [CW-1:0]            hv,
    input  logic [CW-1:0]            hx,
    input  logic [CW-1:0]            hf,
    input  logic [CW-1:0]            hc,
    input  logic [CW-1:0][1:0]       hk,
    input  logic [CW-1:0][SEQ_W-1:0] hs,
    input  logic                     wb_pend,
    output logic [RC_W-1:0]          ret_n,
    output logic                     trap_req,
    output logic                     ns_req,
    output logic                     ns_unc,
    output logic [SEQ_W-1:0]         ns_seq_o,
    output logic                     st_ret
);

    // Walk the head window in order; the first blocker ends the walk (R2).
    always_comb begin
        logic halt;
        halt     = 1'b0;
        ret_n    = '0;
        trap_req = 1'b0;
        ns_req   = 1'b0;
        ns_unc   = 1'b0;
        ns_seq_o = '0;
        st_ret   = 1'b0;
        for (int i = 0; i < CW; i++) begin
            if (!halt) begin
                if (!hv[i]) begin
                    halt = 1'b1;
                end else if (!hx[i]) begin
                    halt = 1'b1;
                    // serialized or uncached send-back (R6, R7)
                    if (hc[i] && (hk[i] == EK_SERIAL || hk[i] == EK_LOAD) &&
                        ret_n == '0 && !wb_pend) begin
                        ns_req   = 1'b1;
                        ns_unc   = (hk[i] == EK_LOAD);
                        ns_seq_o = hs[i];
                    end
                end else if (hf[i]) begin
                    halt = 1'b1;
                    // trap only as the first entry with stores drained (R3)
                    if (ret_n == '0 && !wb_pend) begin
                        trap_req = 1'b1;
                    end
                end else begin
                    ret_n = ret_n + RC_W'(1);
                    if (hk[i] == EK_STORE) begin
                        st_ret = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/commit_thread_ctl.sv
module commit_thread_ctl
    import commit_pkg::*;
#(
    parameter int SEQ_W = 8,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [LAT_W-1:0] trap_latency,
    input  logic             scan_trap,
    input  logic             scan_any_ret,
    input  logic             head0_valid,
    input  logic [SEQ_W-1:0] head0_seq,
    input  logic             sq_done,
    input  logic             ex_req,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic             ctx_req,
    input  logic             ren_valid,
    input  logic             ren_squashed,
    output logic [1:0]       state_o,
    output logic             retire_en,
    output logic             trap_take,
    output logic             sq_valid,
    output logic             sq_all,
    output logic [SEQ_W-1:0] sq_seq,
    output logic             ins_accept,
    output logic             changed
);

    typedef struct packed {
        thr_state_e       st;
        logic [LAT_W-1:0] tmr;
    } ctl_regs_t;

    ctl_regs_t ctl_q, ctl_d;

    logic fire, ctx_go, ex_go, can_squash;

    always_comb begin
        ctl_d = ctl_q;

        // trap event expires: squash the whole thread (R4)
        fire       = (ctl_q.st == TS_TRAP) && (ctl_q.tmr <= LAT_W'(1));
        can_squash = (ctl_q.st == TS_RUN) || (ctl_q.st == TS_SQUASH);
        ctx_go     = ctx_req && can_squash;             // R8
        ex_go      = ex_req && can_squash && !ctx_go;   // R9

        sq_valid = fire || ctx_go || ex_go;
        sq_all   = fire || ctx_go;
        if (sq_all) begin
            sq_seq = head0_valid ? (head0_seq - SEQ_W'(1)) : '0;
        end else if (ex_go) begin
            sq_seq = ex_seq - {{(SEQ_W-1){1'b0}}, ex_incl};
        end else begin
            sq_seq = '0;
        end

        retire_en  = (ctl_q.st == TS_RUN) && !sq_valid;
        trap_take  = retire_en && scan_trap;
        ins_accept = ren_valid && !ren_squashed &&
                     (ctl_q.st == TS_IDLE || ctl_q.st == TS_RUN);   // R10
        changed    = ins_accept || (retire_en && scan_any_ret) || sq_valid;

        unique case (ctl_q.st)
            TS_IDLE: begin
                if (active) ctl_d.st = TS_RUN;
            end
            TS_RUN: begin
                if (sq_valid) begin
                    ctl_d.st = TS_SQUASH;
                end else if (trap_take) begin
                    ctl_d.st  = TS_TRAP;
                    ctl_d.tmr = (trap_latency == '0) ? LAT_W'(1) : trap_latency;
                end
            end
            TS_SQUASH: begin
                if (!sq_valid && sq_done) ctl_d.st = TS_RUN;
            end
            TS_TRAP: begin
                if (fire) begin
                    ctl_d.st = TS_SQUASH;
                end else begin
                    ctl_d.tmr = ctl_q.tmr - LAT_W'(1);
                end
            end
            default: ctl_d.st = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st  <= TS_IDLE;
            ctl_q.tmr <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o = ctl_q.st;

endmodule

// File: rtl/commit_occ_report.sv
module commit_occ_report #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             changed,
    input  logic [CNT_W-1:0] occ,
    input  logic             wb_pend,
    input  logic             store_ret,
    output logic             free_upd,
    output logic [CNT_W-1:0] free_cnt,
    output logic             empty_upd
);

    typedef struct packed {
        logic             chg;
        logic             echk;
        logic             free_upd;
        logic             empty_upd;
        logic [CNT_W-1:0] free_cnt;
    } rep_regs_t;

    rep_regs_t rep_q, rep_d;
    logic      occ_zero, chk_eff, emp_now;

    always_comb begin
        rep_d    = rep_q;
        occ_zero = (occ == '0);
        // a count change seen at zero occupancy arms the empty check (R12)
        chk_eff  = rep_q.echk || (rep_q.chg && occ_zero);
        emp_now  = chk_eff && occ_zero && !wb_pend && !store_ret;

        rep_d.chg       = changed;
        rep_d.free_upd  = rep_q.chg;                                   // R11
        rep_d.free_cnt  = rep_q.chg ? (CNT_W'(DEPTH) - occ) : rep_q.free_cnt;
        rep_d.empty_upd = emp_now;
        rep_d.echk      = chk_eff && !emp_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign free_upd  = rep_q.free_upd;
    assign free_cnt  = rep_q.free_cnt;
    assign empty_upd = rep_q.empty_upd;

endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
    import commit_pkg::*;
#(
    parameter  int NT    = 2,
    parameter  int CW    = 2,
    parameter  int SEQ_W = 8,
    parameter  int DEPTH = 8,
    parameter  int LAT_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int RC_W  = $clog2(CW + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NT-1:0]                    thr_active,
    input  logic [LAT_W-1:0]                 trap_latency,
    input  logic                             st_wb_pending,
    input  logic [NT-1:0][CW-1:0]            head_valid,
    input  logic [NT-1:0][CW-1:0]            head_exec,
    input  logic [NT-1:0][CW-1:0]            head_fault,
    input  logic [NT-1:0][CW-1:0]            head_commitable,
    input  logic [NT-1:0][CW-1:0][1:0]       head_kind,
    input  logic [NT-1:0][CW-1:0][SEQ_W-1:0] head_seq,
    input  logic [NT-1:0][CNT_W-1:0]         rob_occ,
    input  logic [NT-1:0]                    rob_sq_done,
    input  logic [NT-1:0]                    ex_sq_req,
    input  logic [NT-1:0][SEQ_W-1:0]         ex_sq_seq,
    input  logic [NT-1:0]                    ex_sq_incl,
    input  logic [NT-1:0]                    ctx_sq_req,
    input  logic [NT-1:0]                    ren_valid,
    input  logic [NT-1:0]                    ren_squashed,
    output logic [NT-1:0][1:0]               thr_state,
    output logic [NT-1:0][RC_W-1:0]          retire_cnt,
    output logic [NT-1:0]                    trap_take,
    output logic [NT-1:0]                    ns_valid,
    output logic [NT-1:0][SEQ_W-1:0]         ns_seq,
    output logic [NT-1:0]                    ns_uncached,
    output logic [NT-1:0]                    sq_valid,
    output logic [NT-1:0]                    sq_all,
    output logic [NT-1:0][SEQ_W-1:0]         sq_seq,
    output logic [NT-1:0]                    ins_accept,
    output logic [NT-1:0]                    free_upd,
    output logic [NT-1:0][CNT_W-1:0]         free_cnt,
    output logic [NT-1:0]                    empty_upd
);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [RC_W-1:0]  scan_n;
        logic             scan_trap, scan_ns, scan_unc, scan_st;
        logic [SEQ_W-1:0] scan_ns_seq;
        logic             ret_en, chg;

        commit_head_scan #(
            .CW    (CW),
            .SEQ_W (SEQ_W),
            .RC_W  (RC_W)
        ) u_scan (
            .hv       (head_valid[t]),
            .hx       (head_exec[t]),
            .hf       (head_fault[t]),
            .hc       (head_commitable[t]),
            .hk       (head_kind[t]),
            .hs       (head_seq[t]),
            .wb_pend  (st_wb_pending),
            .ret_n    (scan_n),
            .trap_req (scan_trap),
            .ns_req   (scan_ns),
            .ns_unc   (scan_unc),
            .ns_seq_o (scan_ns_seq),
            .st_ret   (scan_st)
        );

        commit_thread_ctl #(
            .SEQ_W (SEQ_W),
            .LAT_W (LAT_W)
        ) u_ctl (
            .clk          (clk),
            .rst_n        (rst_n),
            .active       (thr_active[t]),
            .trap_latency (trap_latency),
            .scan_trap    (scan_trap),
            .scan_any_ret (scan_n != '0),
            .head0_valid  (head_valid[t][0]),
            .head0_seq    (head_seq[t][0]),
            .sq_done      (rob_sq_done[t]),
            .ex_req       (ex_sq_req[t]),
            .ex_seq       (ex_sq_seq[t]),
            .ex_incl      (ex_sq_incl[t]),
            .ctx_req      (ctx_sq_req[t]),
            .ren_valid    (ren_valid[t]),
            .ren_squashed (ren_squashed[t]),
            .state_o      (thr_state[t]),
            .retire_en    (ret_en),
            .trap_take    (trap_take[t]),
            .sq_valid     (sq_valid[t]),
            .sq_all       (sq_all[t]),
            .sq_seq       (sq_seq[t]),
            .ins_accept   (ins_accept[t]),
            .changed      (chg)
        );

        commit_occ_report #(
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) u_rep (
            .clk       (clk),
            .rst_n     (rst_n),
            .changed   (chg),
            .occ       (rob_occ[t]),
            .wb_pend   (st_wb_pending),
            .store_ret (ret_en && scan_st),
            .free_upd  (free_upd[t]),
            .free_cnt  (free_cnt[t]),
            .empty_upd (empty_upd[t])
        );

        assign retire_cnt[t]  = ret_en ? scan_n : '0;
        assign ns_valid[t]    = ret_en && scan_ns;
        assign ns_uncached[t] = ret_en && scan_ns && scan_unc;
        assign ns_seq[t]      = scan_ns_seq;
    end

endmodule

// File: rtl/commit_ctrl_chk.sv
module commit_ctrl_chk #(
    parameter  int NT   = 2,
    parameter  int CW   = 2,
    localparam int RC_W = $clog2(CW + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NT-1:0][1:0]      thr_state,
    input logic [NT-1:0][RC_W-1:0] retire_cnt,
    input logic [NT-1:0]           trap_take,
    input logic                    st_wb_pending,
    input logic [NT-1:0]           ins_accept,
    input logic [NT-1:0]           sq_valid,
    input logic [NT-1:0]           sq_all,
    input logic [NT-1:0]           ns_valid,
    input logic [NT-1:0]           ns_uncached,
    input logic [NT-1:0]           empty_upd
);

    for (genvar t = 0; t < NT; t++) begin : g_chk
        assert_idle_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
            thr_state[t] == 2'd0 |=> (thr_state[t] == 2'd0 || thr_state[t] == 2'd1));

        assert_trap_drained_R3: assert property (@(posedge clk) disable iff (!rst_n)
            trap_take[t] |-> !st_wb_pending);

        assert_trap_enters_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
            trap_take[t] |=> thr_state[t] == 2'd3);

        assert_no_retire_squashing_R5: assert property (@(posedge clk) disable iff (!rst_n)
            thr_state[t] == 2'd2 |-> retire_cnt[t] == '0);

        assert_uncached_tagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ns_uncached[t] |-> ns_valid[t]);

        assert_only_full_squash_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[t] == 2'd3 && sq_valid[t]) |-> sq_all[t]);

        assert_insert_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ins_accept[t] |-> (thr_state[t] == 2'd0 || thr_state[t] == 2'd1));

        assert_empty_after_drain_R12: assert property (@(posedge clk) disable iff (!rst_n)
            empty_upd[t] |-> $past(!st_wb_pending));
    end

endmodule

bind commit_ctrl commit_ctrl_chk #(
    .NT (NT),
    .CW (CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .thr_state     (thr_state),
    .retire_cnt    (retire_cnt),
    .trap_take     (trap_take),
    .st_wb_pending (st_wb_pending),
    .ins_accept    (ins_accept),
    .sq_valid      (sq_valid),
    .sq_all        (sq_all),
    .ns_valid      (ns_valid),
    .ns_uncached   (ns_uncached),
    .empty_upd     (empty_upd)
);

// File: tb/test_commit_ctrl.sv
module test_commit_ctrl;

    localparam int CLK_P = 10;
    localparam int NT    = 2;
    localparam int CW    = 2;
    localparam int SEQ_W = 8;
    localparam int DEPTH = 8;
    localparam int LAT_W = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int RC_W  = $clog2(CW + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic [NT-1:0]                    thr_active;
    logic [LAT_W-1:0]                 trap_latency;
    logic                             st_wb_pending;
    logic [NT-1:0][CW-1:0]            head_valid, head_exec, head_fault, head_commitable;
    logic [NT-1:0][CW-1:0][1:0]       head_kind;
    logic [NT-1:0][CW-1:0][SEQ_W-1:0] head_seq;
    logic [NT-1:0][CNT_W-1:0]         rob_occ;
    logic [NT-1:0]                    rob_sq_done, ex_sq_req, ex_sq_incl, ctx_sq_req;
    logic [NT-1:0][SEQ_W-1:0]         ex_sq_seq;
    logic [NT-1:0]                    ren_valid, ren_squashed;
    logic [NT-1:0][1:0]               thr_state;
    logic [NT-1:0][RC_W-1:0]          retire_cnt;
    logic [NT-1:0]                    trap_take, ns_valid, ns_uncached;
    logic [NT-1:0][SEQ_W-1:0]         ns_seq, sq_seq;
    logic [NT-1:0]                    sq_valid, sq_all, ins_accept, free_upd, empty_upd;
    logic [NT-1:0][CNT_W-1:0]         free_cnt;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_P/2) clk = ~clk;

    commit_ctrl #(
        .NT(NT), .CW(CW), .SEQ_W(SEQ_W), .DEPTH(DEPTH), .LAT_W(LAT_W)
    ) i_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .trap_latency(trap_latency),
        .st_wb_pending(st_wb_pending), .head_valid(head_valid), .head_exec(head_exec),
        .head_fault(head_fault), .head_commitable(head_commitable), .head_kind(head_kind),
        .head_seq(head_seq), .rob_occ(rob_occ), .rob_sq_done(rob_sq_done),
        .ex_sq_req(ex_sq_req), .ex_sq_seq(ex_sq_seq), .ex_sq_incl(ex_sq_incl),
        .ctx_sq_req(ctx_sq_req), .ren_valid(ren_valid), .ren_squashed(ren_squashed),
        .thr_state(thr_state), .retire_cnt(retire_cnt), .trap_take(trap_take),
        .ns_valid(ns_valid), .ns_seq(ns_seq), .ns_uncached(ns_uncached),
        .sq_valid(sq_valid), .sq_all(sq_all), .sq_seq(sq_seq), .ins_accept(ins_accept),
        .free_upd(free_upd), .free_cnt(free_cnt), .empty_upd(empty_upd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_head0();
        head_valid[0] = '0; head_exec[0] = '0; head_fault[0] = '0;
        head_commitable[0] = '0; head_kind[0] = '0; head_seq[0] = '0;
    endtask

    // entry i of thread 0: valid, exec, fault, commitable, kind, seq
    task automatic set_ent(input int i, input logic v, input logic x, input logic f,
                           input logic c, input logic [1:0] k, input logic [SEQ_W-1:0] s);
        head_valid[0][i] = v; head_exec[0][i] = x; head_fault[0][i] = f;
        head_commitable[0][i] = c; head_kind[0][i] = k; head_seq[0][i] = s;
    endtask

    // independent model of the head decision: {ns_seq, count, trap, ns, uncached}
    function automatic logic [31:0] model(input logic [11:0] cb, input logic sp);
        logic halt; int n; logic tr, ns, un; logic [7:0] sq;
        halt = 0; n = 0; tr = 0; ns = 0; un = 0; sq = 0;
        for (int i = 0; i < 2; i++) begin
            logic v, x, f, c; logic [1:0] k;
            v = cb[6*i]; x = cb[6*i+1]; f = cb[6*i+2]; c = cb[6*i+3];
            k = cb[6*i+4 +: 2];
            if (!halt) begin
                if (!v) halt = 1;
                else if (!x) begin
                    halt = 1;
                    if (c && k >= 2'd2 && n == 0 && !sp) begin
                        ns = 1; un = (k == 2'd2); sq = 8'h10 + 8'(i);
                    end
                end else if (f) begin
                    halt = 1;
                    if (n == 0 && !sp) tr = 1;
                end else n++;
            end
        end
        return {13'd0, sq, 8'(n), tr, ns, un};
    endfunction

    initial begin
        #(CLK_P * 150000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        rst_n = 0; thr_active = '0; trap_latency = '0; st_wb_pending = 0;
        head_valid = '0; head_exec = '0; head_fault = '0; head_commitable = '0;
        head_kind = '0; head_seq = '0; rob_occ = '0; rob_sq_done = '0;
        ex_sq_req = '0; ex_sq_seq = '0; ex_sq_incl = '0; ctx_sq_req = '0;
        ren_valid = '0; ren_squashed = '0;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 reset state", 32'(thr_state), 32'd0);
        chk("R1 reset pulses", 32'({sq_valid, trap_take, free_upd, empty_upd}), 32'd0);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #2;
        chk("R1 stays idle without enable", 32'(thr_state), 32'd0);
        thr_active = 2'b11;
        @(negedge clk); #2;
        chk("R1 idle to running", 32'(thr_state), 32'b0101);

        // R2 R3 R6 R7: exhaustive head-window sweep on thread 0
        for (int sp = 0; sp < 2; sp++) begin
            for (int cbi = 0; cbi < 4096; cbi++) begin
                logic [11:0] cb;
                logic [31:0] act;
                cb = 12'(cbi);
                @(negedge clk);
                st_wb_pending = sp[0];
                for (int i = 0; i < 2; i++)
                    set_ent(i, cb[6*i], cb[6*i+1], cb[6*i+2], cb[6*i+3], cb[6*i+4 +: 2], 8'h10 + 8'(i));
                #2;
                act = {13'd0, ns_valid[0] ? ns_seq[0] : 8'd0, 8'(retire_cnt[0]),
                       trap_take[0], ns_valid[0], ns_uncached[0]};
                chk("R2 R3 R6 R7 head sweep", act, model(cb, sp[0]));
                #1;
                clear_head0();
                st_wb_pending = 0;
            end
        end
        @(negedge clk); #2;
        chk("R2 sweep left thread running", 32'(thr_state[0]), 32'd1);

        // R4 R5 R8: trap latency sweep
        for (int lat = 0; lat < 5; lat++) begin
            int leff;
            leff = (lat == 0) ? 1 : lat;
            trap_latency = LAT_W'(lat);
            @(negedge clk);
            set_ent(0, 1, 1, 1, 1, 2'd0, 8'h40);
            #2;
            chk("R3 trap raised", 32'(trap_take[0]), 32'd1);
            for (int k = 1; k <= leff; k++) begin
                @(negedge clk);
                clear_head0();
                if (lat % 2 == 0) set_ent(0, 1, 1, 0, 1, 2'd0, 8'h40);
                if (k == 1) begin
                    ctx_sq_req[0] = 1; ex_sq_req[0] = 1; ex_sq_seq[0] = 8'h22;
                    ren_valid[0] = 1;
                end
                #2;
                chk("R4 trap pending state", 32'(thr_state[0]), 32'd3);
                chk("R4 squash-all timing", 32'({sq_valid[0], sq_all[0]}),
                    (k == leff) ? 32'd3 : 32'd0);
                if (k == leff)
                    chk("R4 squash-all seq", 32'(sq_seq[0]),
                        (lat % 2 == 0) ? 32'h3f : 32'h0);
                if (k == 1) begin
                    chk("R10 insert blocked in trap wait", 32'(ins_accept[0]), 32'd0);
                    chk("R5 no retire in trap wait", 32'(retire_cnt[0]), 32'd0);
                end
                #1;
                ctx_sq_req[0] = 0; ex_sq_req[0] = 0; ren_valid[0] = 0;
            end
            @(negedge clk);
            set_ent(0, 1, 1, 0, 1, 2'd0, 8'h41);
            set_ent(1, 1, 1, 0, 1, 2'd0, 8'h42);
            #2;
            chk("R4 enters squashing", 32'(thr_state[0]), 32'd2);
            chk("R5 no retire while squashing", 32'(retire_cnt[0]), 32'd0);
            rob_sq_done[0] = 1;
            @(negedge clk);
            rob_sq_done[0] = 0;
            #2;
            chk("R5 back to running", 32'(thr_state[0]), 32'd1);
            chk("R2 two retire after recovery", 32'(retire_cnt[0]), 32'd2);
            #1;
            clear_head0();
        end

        // R9 R8: execute and context squashes
        @(negedge clk);
        set_ent(0, 1, 1, 0, 1, 2'd0, 8'h50);
        set_ent(1, 1, 1, 0, 1, 2'd0, 8'h51);
        ex_sq_req[0] = 1; ex_sq_seq[0] = 8'h20; ex_sq_incl[0] = 1;
        #2;
        chk("R9 exec squash with include", 32'({sq_valid[0], sq_all[0], sq_seq[0]}), 32'h21f);
        chk("R9 no retire on squash cycle", 32'(retire_cnt[0]), 32'd0);
        @(negedge clk);
        ex_sq_seq[0] = 8'h30; ex_sq_incl[0] = 0; ren_valid[0] = 1;
        #2;
        chk("R9 exec squash accepted while squashing", 32'({sq_valid[0], sq_all[0], sq_seq[0]}), 32'h230);
        chk("R10 insert blocked while squashing", 32'(ins_accept[0]), 32'd0);
        @(negedge clk);
        ren_valid[0] = 0;
        ctx_sq_req[0] = 1;
        #2;
        chk("R8 context beats execute", 32'({sq_valid[0], sq_all[0], sq_seq[0]}), 32'h34f);
        @(negedge clk);
        ctx_sq_req[0] = 0; ex_sq_req[0] = 0; ex_sq_incl[0] = 0;
        rob_sq_done[0] = 1;
        clear_head0();
        @(negedge clk);
        rob_sq_done[0] = 0;
        #2;
        chk("R5 squash done resumes", 32'(thr_state[0]), 32'd1);
        ren_valid[0] = 1; ren_squashed[0] = 0;
        #1;
        chk("R10 insert accepted when running", 32'(ins_accept[0]), 32'd1);
        ren_squashed[0] = 1;
        #1;
        chk("R10 squashed entry refused", 32'(ins_accept[0]), 32'd0);
        ren_valid[0] = 0; ren_squashed[0] = 0;

        // R11: free-entry report with nonzero occupancy
        rob_occ[0] = CNT_W'(3);
        repeat (4) @(negedge clk);
        ren_valid[0] = 1;
        #2;
        chk("R11 quiet before change", 32'(free_upd[0]), 32'd0);
        @(negedge clk);
        ren_valid[0] = 0;
        #2;
        chk("R11 not one cycle early", 32'(free_upd[0]), 32'd0);
        @(negedge clk); #2;
        chk("R11 free notice", 32'({free_upd[0], free_cnt[0]}), 32'h15);
        chk("R12 no empty with entries", 32'(empty_upd[0]), 32'd0);
        @(negedge clk); #2;
        chk("R11 notice is one pulse", 32'(free_upd[0]), 32'd0);

        // R12: empty held while stores pending
        rob_occ[0] = '0;
        st_wb_pending = 1;
        @(negedge clk);
        ren_valid[0] = 1;
        @(negedge clk);
        ren_valid[0] = 0;
        @(negedge clk); #2;
        chk("R11 free notice at zero", 32'({free_upd[0], free_cnt[0]}), 32'h18);
        chk("R12 empty held by pending stores", 32'(empty_upd[0]), 32'd0);
        @(negedge clk); #2;
        chk("R12 still held", 32'(empty_upd[0]), 32'd0);
        #1;
        st_wb_pending = 0;
        @(negedge clk); #2;
        chk("R12 empty after drain", 32'(empty_upd[0]), 32'd1);
        @(negedge clk); #2;
        chk("R12 empty is one pulse", 32'(empty_upd[0]), 32'd0);

        // R12: store retiring in the check cycle holds empty back
        repeat (2) @(negedge clk);
        ren_valid[0] = 1;
        @(negedge clk);
        ren_valid[0] = 0;
        set_ent(0, 1, 1, 0, 1, 2'd1, 8'h60);
        #2;
        chk("R2 store retires", 32'(retire_cnt[0]), 32'd1);
        @(negedge clk);
        clear_head0();
        #2;
        chk("R12 held by retiring store", 32'({free_upd[0], empty_upd[0]}), 32'b10);
        @(negedge clk); #2;
        chk("R12 empty after store cycle", 32'(empty_upd[0]), 32'd1);
        chk("R1 thread 1 untouched", 32'(thr_state[1]), 32'd1);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule